// File: doc/BRIEF.md
# Frequency Lock Detector with Clock Fallback

This block decides, one channel at a time, whether a recovered line clock can be trusted. It runs mostly in a local reference clock domain. A gate window of a fixed number of reference cycles is timed there. The line clock drives an edge counter of its own. At the end of each gate, a toggle handshake carries that counter's snapshot across into the reference domain. The snapshot is compared with the nominal count. The channel then sits in one of two modes. In training mode the line is not trusted, so the block raises loss-of-lock and points the output clock selector at the reference. In recovery mode loss-of-lock is low and the selector points at the line clock.

A loss-of-signal input, synchronous to the reference clock, forces training straight away, whatever the counts say. A line clock that has stopped is caught because its handshake never completes. Lock is declared only after a number of consecutive good windows. Any bad window drops it. The gate length, the tolerance in counts and the number of good windows needed are parameters. The defaults are 2048 cycles, ±10 counts (about 0.5 %) and 2 windows.

Top module: `fld_lock_detect`

## Requirements
- R1: While reset is asserted and just after it, `lol` is 1 and `clkSel` is 0.
- R2: In training mode `lol`=1 and `clkSel`=0, where 0 selects the reference clock. In recovery mode `lol`=0 and `clkSel`=1, where 1 selects the line clock. The two outputs are never equal.
- R3: Each window counts the line-clock edges that fall within `GATE_LEN` reference cycles. The window is good when the count is within `TOL` of `GATE_LEN` (defaults 2048 and ±10). A line clock off by about 0.2 % gives good windows. One off by about 0.8 % gives bad windows.
- R4: `lol` falls only on the cycle after a good window result arrives while `los` is low. At least `LOCK_WINS` (default 2) consecutive good results are needed first.
- R5: A bad window result forces training mode on the next reference edge.
- R6: With `los`=1 the block enters training mode on the next reference edge. It stays there as long as `los` stays high, even if the line frequency is in tolerance.
- R7: Results that arrive while `los` is high do not count toward lock. After `los` falls, lock needs `LOCK_WINS` fresh good results, so `lol` stays high for at least one further gate window.
- R8: If a gate ends while the previous snapshot request is still unanswered, which happens when the line clock has stopped, the block enters training mode.
- R9: Two kinds of result are discarded. One is the first result after reset. The other is a late result whose request spanned a missed window. Neither counts as good or bad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Local reference clock, same nominal rate as the line |
| lineClk | input | 1 | Recovered line clock |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| los | input | 1 | Loss-of-signal indication, synchronous to refClk |
| lol | output | 1 | Loss-of-lock flag, high in training mode |
| clkSel | output | 1 | Output clock select: 0 reference, 1 line |

## Verification
The bench times the first lock after reset exactly, to the window edge. Any of three mistakes would show up as early lock: counting the unsettled first window, locking on a single good window, or changing state between results. The stimulus table walks the line period across both sides of the tolerance band and requires lock to follow. A comparator with the wrong sign or the wrong bound would lock on the 0.8 % settings or lose lock on the 0.2 % ones. Directed tests hold `los` high over an in-tolerance line, where a missing override would keep the line clock selected. They also check that lock is not regained within one window of `los` falling, and stop the line clock altogether. A design without a timeout on the handshake would keep reporting lock on a dead clock.

// File: rtl/fld_pkg.sv
`timescale 1ns/1ps
package fld_pkg;
  typedef enum logic {
    MODE_TRAIN   = 1'b0,
    MODE_RECOVER = 1'b1
  } fldMode_e;

  // one-cycle strobes from datapath to control, refClk domain
  typedef struct packed {
    logic resValid;  // a usable window result arrived
    logic inTol;     // qualifies resValid: count within tolerance
    logic missed;    // gate ended with request still outstanding
  } fldStrobe_t;
endpackage

// File: rtl/fld_sync2.sv
`timescale 1ns/1ps
module fld_sync2 #(
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= RESET_VAL;
      q    <= RESET_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fld_line_count.sv
`timescale 1ns/1ps
// Line-domain edge counter; snapshots and restarts on each request toggle.
module fld_line_count #(
  parameter int CNT_W = 13
) (
  input  logic             lineClk,
  input  logic             lineRstN,
  input  logic             reqTog,
  output logic             ackTog,
  output logic [CNT_W-1:0] capCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             reqSync;
  logic             reqSeen;
  logic             capture;
  logic [CNT_W-1:0] edgeCnt;
  logic [CNT_W-1:0] edgeInc;

  fld_sync2 #(.RESET_VAL(1'b0)) u_reqSync (
    .clk (lineClk),
    .rstN(lineRstN),
    .d   (reqTog),
    .q   (reqSync)
  );

  assign capture = reqSync ^ reqSeen;
  assign edgeInc = (edgeCnt == CNT_MAX) ? edgeCnt : edgeCnt + CNT_W'(1);

  always_ff @(posedge lineClk or negedge lineRstN) begin
    if (!lineRstN) begin
      reqSeen  <= 1'b0;
      edgeCnt  <= '0;
      capCount <= '0;
      ackTog   <= 1'b0;
    end else begin
      reqSeen <= reqSync;
      if (capture) begin
        capCount <= edgeInc;   // this edge belongs to the closing window
        edgeCnt  <= '0;
        ackTog   <= ~ackTog;
      end else begin
        edgeCnt <= edgeInc;
      end
    end
  end
endmodule

// File: rtl/fld_datapath.sv
`timescale 1ns/1ps
module fld_datapath
  import fld_pkg::*;
#(
  parameter int GATE_LEN = 2048,
  parameter int TOL      = 10
) (
  input  logic       refClk,
  input  logic       lineClk,
  input  logic       rstN,
  output fldStrobe_t stb
);
  localparam int GATE_W = $clog2(GATE_LEN);
  localparam int CNT_W  = $clog2(GATE_LEN) + 2;
  localparam logic [GATE_W-1:0] GATE_LAST = GATE_W'(GATE_LEN - 1);
  localparam logic [CNT_W-1:0]  NOMINAL   = CNT_W'(GATE_LEN);
  localparam logic [CNT_W-1:0]  TOL_CNT   = CNT_W'(TOL);

  logic              lineRstN;
  logic [GATE_W-1:0] gateCnt;
  logic              gateEnd;
  logic              reqTog;
  logic              pending;
  logic              stale;
  logic              ackTog;
  logic              ackSync;
  logic              ackSeen;
  logic              ackEdge;
  logic              reqIssue;
  logic              missNow;
  logic [CNT_W-1:0]  capCount;
  logic [CNT_W-1:0]  countDiff;
  logic              inTolNow;
  logic              resValidQ;
  logic              inTolQ;
  logic              missedQ;

  // line-domain reset release
  fld_sync2 #(.RESET_VAL(1'b0)) u_lineRst (
    .clk (lineClk),
    .rstN(rstN),
    .d   (1'b1),
    .q   (lineRstN)
  );

  fld_line_count #(.CNT_W(CNT_W)) u_lineCount (
    .lineClk (lineClk),
    .lineRstN(lineRstN),
    .reqTog  (reqTog),
    .ackTog  (ackTog),
    .capCount(capCount)
  );

  fld_sync2 #(.RESET_VAL(1'b0)) u_ackSync (
    .clk (refClk),
    .rstN(rstN),
    .d   (ackTog),
    .q   (ackSync)
  );

  assign gateEnd  = (gateCnt == GATE_LAST);
  assign ackEdge  = ackSync ^ ackSeen;
  assign reqIssue = gateEnd && (!pending || ackEdge);
  assign missNow  = gateEnd && pending && !ackEdge;

  assign countDiff = (capCount >= NOMINAL) ? (capCount - NOMINAL) : (NOMINAL - capCount);
  assign inTolNow  = (countDiff <= TOL_CNT);

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      gateCnt   <= '0;
      reqTog    <= 1'b0;
      pending   <= 1'b0;
      stale     <= 1'b1;   // first window after reset is unsettled
      ackSeen   <= 1'b0;
      resValidQ <= 1'b0;
      inTolQ    <= 1'b0;
      missedQ   <= 1'b0;
    end else begin
      ackSeen <= ackSync;
      gateCnt <= gateEnd ? '0 : gateCnt + GATE_W'(1);

      if (reqIssue) begin
        reqTog  <= ~reqTog;
        pending <= 1'b1;
      end else if (ackEdge) begin
        pending <= 1'b0;
      end

      if (missNow) begin
        stale <= 1'b1;
      end else if (ackEdge) begin
        stale <= 1'b0;
      end

      resValidQ <= ackEdge && !stale;
      inTolQ    <= ackEdge && !stale && inTolNow;
      missedQ   <= missNow;
    end
  end

  always_comb begin
    stb.resValid = resValidQ;
    stb.inTol    = inTolQ;
    stb.missed   = missedQ;
  end
endmodule

// File: rtl/fld_ctrl.sv
`timescale 1ns/1ps
module fld_ctrl
  import fld_pkg::*;
#(
  parameter int LOCK_WINS = 2
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       los,
  input  fldStrobe_t stb,
  output logic       lol,
  output logic       clkSel
);
  localparam int GOOD_W = $clog2(LOCK_WINS + 1);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_WINS - 1);

  fldMode_e          mode;
  logic [GOOD_W-1:0] goodRun;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      mode    <= MODE_TRAIN;
      goodRun <= '0;
    end else if (los || stb.missed) begin
      mode    <= MODE_TRAIN;
      goodRun <= '0;
    end else if (stb.resValid) begin
      if (stb.inTol) begin
        if (goodRun >= GOOD_LAST) begin
          mode    <= MODE_RECOVER;
          goodRun <= GOOD_LAST;
        end else begin
          goodRun <= goodRun + GOOD_W'(1);
        end
      end else begin
        mode    <= MODE_TRAIN;
        goodRun <= '0;
      end
    end
  end

  assign lol    = (mode == MODE_TRAIN);
  assign clkSel = (mode == MODE_RECOVER);
endmodule

// File: rtl/fld_lock_detect.sv
`timescale 1ns/1ps
module fld_lock_detect
  import fld_pkg::*;
#(
  parameter int GATE_LEN  = 2048,
  parameter int TOL       = 10,
  parameter int LOCK_WINS = 2
) (
  input  logic refClk,
  input  logic lineClk,
  input  logic rstN,
  input  logic los,
  output logic lol,
  output logic clkSel
);
  fldStrobe_t stb;

  fld_datapath #(.GATE_LEN(GATE_LEN), .TOL(TOL)) u_datapath (
    .refClk (refClk),
    .lineClk(lineClk),
    .rstN   (rstN),
    .stb    (stb)
  );

  fld_ctrl #(.LOCK_WINS(LOCK_WINS)) u_ctrl (
    .refClk(refClk),
    .rstN  (rstN),
    .los   (los),
    .stb   (stb),
    .lol   (lol),
    .clkSel(clkSel)
  );
endmodule

// File: rtl/fld_lock_chk.sv
`timescale 1ns/1ps
module fld_lock_chk
  import fld_pkg::*;
(
  input logic       refClk,
  input logic       rstN,
  input logic       los,
  input logic       lol,
  input logic       clkSel,
  input fldStrobe_t stb
);
  // R2
  lol_sel_excl_chk: assert property (@(posedge refClk) disable iff (!rstN)
    lol != clkSel);

  // R6
  los_train_chk: assert property (@(posedge refClk) disable iff (!rstN)
    los |=> lol);

  // R4
  lock_on_result_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(lol) |-> $past(stb.resValid && stb.inTol && !los));

  // R5
  bad_result_train_chk: assert property (@(posedge refClk) disable iff (!rstN)
    (stb.resValid && !stb.inTol) |=> lol);

  // R8
  missed_train_chk: assert property (@(posedge refClk) disable iff (!rstN)
    stb.missed |=> lol);

  // R9
  discard_excl_chk: assert property (@(posedge refClk) disable iff (!rstN)
    !(stb.resValid && stb.missed));

  // R5
  unlock_cause_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(lol) |-> $past(los || stb.missed || (stb.resValid && !stb.inTol)));
endmodule

bind fld_lock_detect fld_lock_chk u_lockChk (
  .refClk(refClk),
  .rstN  (rstN),
  .los   (los),
  .lol   (lol),
  .clkSel(clkSel),
  .stb   (stb)
);

// File: tb/tb_fld_lock_detect.sv
`timescale 1ns/1ps
module tb_fld_lock_detect;
  localparam int GATE = 2048;

  typedef struct packed {
    int unsigned halfPs;
    logic        lock;
  } vec_t;

  // line half-period in ps and expected lock state after settling (R3, R5)
  localparam int VEC_N = 6;
  localparam vec_t VECS [VEC_N] = '{
    '{32'd2520, 1'b0},   // ~0.8% slow
    '{32'd2495, 1'b1},   // ~0.2% fast
    '{32'd2480, 1'b0},   // ~0.8% fast
    '{32'd2505, 1'b1},   // ~0.2% slow
    '{32'd2500, 1'b1},   // nominal
    '{32'd2500, 1'b1}
  };

  logic refClk = 1'b0;
  logic lineClk = 1'b0;
  logic rstN = 1'b0;
  logic los = 1'b0;
  logic lol;
  logic clkSel;

  real lineHalf = 2.5;
  bit  lineRun = 1'b1;
  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  fld_lock_detect dut (
    .refClk (refClk),
    .lineClk(lineClk),
    .rstN   (rstN),
    .los    (los),
    .lol    (lol),
    .clkSel (clkSel)
  );

  always #2.5 refClk = ~refClk;

  initial begin
    forever begin
      #(lineHalf);
      if (lineRun) lineClk = ~lineClk;
    end
  end

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic waitRef(input int n);
    repeat (n) @(posedge refClk);
    #1;
  endtask

  task automatic expectLock(input string tag, input logic locked);
    check({tag, " lol"}, lol, !locked);
    check({tag, " clkSel"}, clkSel, locked);
  endtask

  initial begin
    #950000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    waitRef(5);
    expectLock("R1 in reset", 1'b0);
    @(negedge refClk);
    rstN = 1'b1;
    waitRef(1);
    expectLock("R1 after release", 1'b0);

    // R9 + R4: first window discarded, one good window not enough
    waitRef(2 * GATE + 29);
    expectLock("R9 R4 one good window", 1'b0);
    waitRef(GATE - 50);
    expectLock("R4 just before second result", 1'b0);
    waitRef(50);
    expectLock("R4 R2 locked after two good windows", 1'b1);

    // R3 R5: table of line periods
    for (int i = 0; i < VEC_N; i++) begin
      lineHalf = real'(VECS[i].halfPs) / 1000.0;
      waitRef(3 * GATE + 100);
      expectLock($sformatf("R3 R5 vec%0d half=%0dps", i, VECS[i].halfPs), VECS[i].lock);
    end

    // R6: loss of signal overrides an in-tolerance line
    @(negedge refClk);
    los = 1'b1;
    waitRef(1);
    expectLock("R6 los forces training", 1'b0);
    waitRef(3000);
    expectLock("R6 held during los", 1'b0);
    @(negedge refClk);
    los = 1'b0;
    // R7: relock needs fresh windows
    waitRef(2000);
    expectLock("R7 no instant relock", 1'b0);
    waitRef(2 * GATE + 100 - 2000 + 100);
    expectLock("R7 relocked after fresh windows", 1'b1);

    // R8: stopped line clock
    lineRun = 1'b0;
    waitRef(2 * GATE + 100);
    expectLock("R8 dead line clock", 1'b0);
    waitRef(GATE);
    expectLock("R8 still training", 1'b0);
    lineRun = 1'b1;
    // R9: late result after restart discarded, then relock
    waitRef(4 * GATE + 100);
    expectLock("R9 relock after restart", 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule